// File: doc/BRIEF.md
# Binary Max-Pool Unit with Early Pool Termination

This unit follows the sign activation of one processing element in a binarized network engine. Activations arrive one per cycle as single bits, where a 1 stands for +1 and a 0 for -1. Because the activation has already been binarized, the maximum over a pooling window is simply the OR of its bits. The unit tracks the position of each arriving bit inside the current window and drives writes into the element's output cache.

The first 1 seen in a window decides the result, so the unit writes a 1 into that window's cache slot at once. In the same cycle it raises a flush request for the compute pipeline and a skip request that carries how many window elements remain unevaluated. The address generator uses this count to jump past them. Cache bits that those skipped computations would have produced are never written, because the pooled 1 already stands for the whole window. If a window ends without a 1, a 0 is written after its last element.

When the layer has no pooling, a bypass input makes every activation write straight through to consecutive cache slots. A saturating counter totals the skipped element count so that skip statistics can be checked.

Top module: `bnn_maxpool_skip`

## Requirements
- R1: While reset is held and after its release, wr_en, wr_bit, skip_req, flush_req and skip_cnt are 0, wr_idx is 0 and skip_total is 0.
- R2: With bypass high, each valid activation produces, on the next cycle, a write with wr_bit equal to act_bit at a cache index one above the previous write's index.
- R3: With bypass low, a valid activation equal to 1 at 0-based position p of a window of size N produces, on the next cycle, a write of 1 at the window's cache index, and the element counter restarts at position 0.
- R4: In the same cycle as the R3 write, skip_req and flush_req are high and skip_cnt equals N-1-p, but only when N-1-p is greater than 0. In every other cycle skip_req and flush_req are low and skip_cnt is 0.
- R5: A window whose N elements are all 0 produces no write for its first N-1 elements and a write of 0 at the window's index on the cycle after its last element.
- R6: In pooled mode the cache index advances by one per completed window, whether it ended early or by its last element. In both modes the index wraps from CACHE_DEPTH-1 to 0.
- R7: A pool_size of 0 is treated as 1, so every activation writes and nothing is skipped. A pool_size above MAX_POOL is treated as MAX_POOL. Every size from 1 to MAX_POOL works, and MAX_POOL is at least 12.
- R8: skip_total is the sum of all skip_cnt values issued since reset, held at its maximum value 2^STAT_W-1 once that value is reached.
- R9: A cycle without act_valid produces no write and no skip on the next cycle, and it leaves the window position and the cache index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid | input | 1 | An activation bit is present this cycle |
| act_bit | input | 1 | Binarized activation, 1 = +1, 0 = -1 |
| pool_size | input | PW | Window length in elements; to be changed only between windows |
| bypass | input | 1 | Layer has no pooling: pass each activation through |
| wr_en | output | 1 | Output-cache write strobe |
| wr_bit | output | 1 | Bit to write; 0 when wr_en is low |
| wr_idx | output | IW | Output-cache slot to write |
| skip_req | output | 1 | Request to skip the rest of the window |
| skip_cnt | output | PW | Number of window elements skipped; 0 when no skip |
| flush_req | output | 1 | Request to flush the compute pipeline |
| skip_total | output | STAT_W | Saturating total of skipped elements |

## Verification
If the element counter drifts, the error shows at the ports on the next window boundary. Either a zero window writes one cycle early or late, or skip_cnt after a hit differs from N-1-p. The bench therefore sweeps every hit position, including no hit at all, for every window size. A stuck or skipped cache index shows up on the next write as a wrong wr_idx, and the long sweep runs the index through several wraps. A wrong skip count or a broken saturation rule shows up in skip_total in the cycle after the skip, and the small statistics width of the bench reaches saturation partway through the sweep.

// File: rtl/bnnpool_pkg.sv
package bnnpool_pkg;

   typedef enum logic [1:0] {
      EV_IDLE = 2'd0,
      EV_PASS = 2'd1,
      EV_HIT  = 2'd2,
      EV_ZERO = 2'd3
   } pool_event_e;

   function automatic int unsigned width_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pool_elem_counter.sv
module pool_elem_counter #(
   parameter int unsigned MAX_POOL = 16,
   parameter int unsigned PW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          restart,
   input  logic          clear,
   input  logic [PW-1:0] size_raw,
   output logic          at_last,
   output logic [PW-1:0] remain
);
   localparam logic [PW-1:0] MAXV = PW'(MAX_POOL);
   localparam logic [PW-1:0] ONE  = PW'(1);

   logic [PW-1:0] pos_q;
   logic [PW-1:0] size_eff;
   logic [PW:0]   pos_next_w;

   always_comb begin
      if (size_raw == '0)
         size_eff = ONE;
      else if (size_raw > MAXV)
         size_eff = MAXV;
      else
         size_eff = size_raw;
   end

   assign pos_next_w = {1'b0, pos_q} + 1'b1;
   assign at_last    = (pos_next_w >= {1'b0, size_eff});
   assign remain     = at_last ? '0 : (size_eff - pos_q - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (clear)
         pos_q <= '0;
      else if (step) begin
         if (restart || at_last)
            pos_q <= '0;
         else
            pos_q <= pos_next_w[PW-1:0];
      end
   end

endmodule

// File: rtl/cache_index_gen.sv
module cache_index_gen #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned IW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [IW-1:0] idx
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0) && (DEPTH == (1 << IW));

   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_n;

   generate
      if (POW2) begin : g_pow2
         always_comb idx_n = idx_q + 1'b1;
      end else begin : g_cmp
         localparam logic [IW-1:0] LASTI = IW'(DEPTH - 1);
         always_comb idx_n = (idx_q == LASTI) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (advance)
         idx_q <= idx_n;
   end

   assign idx = idx_q;

endmodule

// File: rtl/skip_stat_acc.sv
module skip_stat_acc #(
   parameter int unsigned SW = 16,
   parameter int unsigned PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_en,
   input  logic [PW-1:0] add_val,
   output logic [SW-1:0] total
);
   localparam int unsigned AW = ((SW > PW) ? SW : PW) + 1;

   logic [SW-1:0] tot_q;
   logic [AW-1:0] sum_w;
   logic [AW-1:0] cap_w;

   assign cap_w = AW'({SW{1'b1}});
   assign sum_w = AW'(tot_q) + AW'(add_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tot_q <= '0;
      else if (add_en)
         tot_q <= (sum_w > cap_w) ? {SW{1'b1}} : sum_w[SW-1:0];
   end

   assign total = tot_q;

endmodule

// File: rtl/bnn_maxpool_skip.sv
module bnn_maxpool_skip #(
   parameter int unsigned MAX_POOL    = 16,
   parameter int unsigned CACHE_DEPTH = 32,
   parameter int unsigned STAT_W      = 16,
   parameter bit          HAS_POOL    = 1'b1,
   localparam int unsigned PW = bnnpool_pkg::width_for(MAX_POOL),
   localparam int unsigned IW = $clog2(CACHE_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic              act_bit,
   input  logic [PW-1:0]     pool_size,
   input  logic              bypass,
   output logic              wr_en,
   output logic              wr_bit,
   output logic [IW-1:0]     wr_idx,
   output logic              skip_req,
   output logic [PW-1:0]     skip_cnt,
   output logic              flush_req,
   output logic [STAT_W-1:0] skip_total
);
   import bnnpool_pkg::*;

   generate
      if (MAX_POOL < 12) begin : g_bad_pool
         $error("MAX_POOL must be at least 12");
      end
      if (CACHE_DEPTH < 2) begin : g_bad_depth
         $error("CACHE_DEPTH must be at least 2");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("STAT_W must be at least 2");
      end
   endgenerate

   logic          pooled;
   logic          at_last;
   logic [PW-1:0] remain;
   logic [IW-1:0] idx_now;
   pool_event_e   ev;
   logic          advance;
   logic          do_skip;

   generate
      if (HAS_POOL) begin : g_pool
         assign pooled = ~bypass;
      end else begin : g_nopool
         assign pooled = 1'b0;
      end
   endgenerate

   always_comb begin
      ev = EV_IDLE;
      if (act_valid) begin
         if (!pooled)
            ev = EV_PASS;
         else if (act_bit)
            ev = EV_HIT;
         else if (at_last)
            ev = EV_ZERO;
      end
   end

   assign advance = (ev != EV_IDLE);
   assign do_skip = (ev == EV_HIT) && (remain != '0);

   pool_elem_counter #(
      .MAX_POOL (MAX_POOL),
      .PW       (PW)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (act_valid & pooled),
      .restart  (act_bit),
      .clear    (~pooled),
      .size_raw (pool_size),
      .at_last  (at_last),
      .remain   (remain)
   );

   cache_index_gen #(
      .DEPTH   (CACHE_DEPTH),
      .IW      (IW)
   ) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .idx     (idx_now)
   );

   skip_stat_acc #(
      .SW      (STAT_W),
      .PW      (PW)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (do_skip),
      .add_val (remain),
      .total   (skip_total)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_bit    <= 1'b0;
         wr_idx    <= '0;
         skip_req  <= 1'b0;
         skip_cnt  <= '0;
         flush_req <= 1'b0;
      end else begin
         wr_en     <= advance;
         wr_bit    <= (ev == EV_HIT) || ((ev == EV_PASS) && act_bit);
         wr_idx    <= advance ? idx_now : wr_idx;
         skip_req  <= do_skip;
         flush_req <= do_skip;
         skip_cnt  <= do_skip ? remain : '0;
      end
   end

endmodule

// File: rtl/bnn_maxpool_skip_chk.sv
module bnn_maxpool_skip_chk #(
   parameter int unsigned PW = 5,
   parameter int unsigned IW = 5,
   parameter int unsigned SW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          act_valid,
   input logic          act_bit,
   input logic          bypass,
   input logic          wr_en,
   input logic          wr_bit,
   input logic          skip_req,
   input logic [PW-1:0] skip_cnt,
   input logic          flush_req,
   input logic [SW-1:0] skip_total
);
   // R4
   skip_implies_hit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> (wr_en && wr_bit && flush_req && (skip_cnt != '0)));

   // R4
   flush_pairs_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> skip_req);

   // R2
   bypass_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bypass) && $past(act_valid)) |-> (wr_en && (wr_bit == $past(act_bit)) && !skip_req));

   // R9
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(act_valid) |-> (!wr_en && !skip_req));

   // R8
   total_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_total >= $past(skip_total));

   // R8
   total_still_without_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !skip_req |-> $stable(skip_total));

endmodule

bind bnn_maxpool_skip bnn_maxpool_skip_chk #(
   .PW (PW),
   .IW (IW),
   .SW (STAT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .act_valid  (act_valid),
   .act_bit    (act_bit),
   .bypass     (bypass),
   .wr_en      (wr_en),
   .wr_bit     (wr_bit),
   .skip_req   (skip_req),
   .skip_cnt   (skip_cnt),
   .flush_req  (flush_req),
   .skip_total (skip_total)
);

// File: tb/bnn_maxpool_skip_bench.sv
module bnn_maxpool_skip_bench;
   localparam int unsigned MAXP   = 16;
   localparam int unsigned DEPTH  = 32;
   localparam int unsigned SW     = 6;
   localparam int unsigned PW     = 5;
   localparam int unsigned IW     = 5;
   localparam int unsigned SATV   = (1 << SW) - 1;
   localparam time         PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_valid = 1'b0;
   logic          act_bit = 1'b0;
   logic [PW-1:0] pool_size = '0;
   logic          bypass = 1'b0;
   logic          wr_en, wr_bit, skip_req, flush_req;
   logic [IW-1:0] wr_idx;
   logic [PW-1:0] skip_cnt;
   logic [SW-1:0] skip_total;

   int checks = 0;
   int errors = 0;
   int unsigned exp_idx = 0;
   int unsigned exp_tot = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   bnn_maxpool_skip #(
      .MAX_POOL    (MAXP),
      .CACHE_DEPTH (DEPTH),
      .STAT_W      (SW),
      .HAS_POOL    (1'b1)
   ) u_bnn_maxpool_skip (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_valid  (act_valid),
      .act_bit    (act_bit),
      .pool_size  (pool_size),
      .bypass     (bypass),
      .wr_en      (wr_en),
      .wr_bit     (wr_bit),
      .wr_idx     (wr_idx),
      .skip_req   (skip_req),
      .skip_cnt   (skip_cnt),
      .flush_req  (flush_req),
      .skip_total (skip_total)
   );

   task automatic compare(input string req, input bit e_wr, input bit e_bit,
                          input int unsigned e_skip);
      bit ok;
      checks++;
      ok = (wr_en == e_wr) && (wr_bit == (e_wr & e_bit)) &&
           (!e_wr || (wr_idx == IW'(exp_idx))) &&
           (skip_req == (e_skip != 0)) && (flush_req == (e_skip != 0)) &&
           (skip_cnt == PW'(e_skip)) && (skip_total == SW'(exp_tot));
      if (!ok) begin
         errors++;
         $display("FAIL %s: got wr=%0b bit=%0b idx=%0d skip=%0b flush=%0b cnt=%0d tot=%0d exp wr=%0b bit=%0b idx=%0d cnt=%0d tot=%0d",
                  req, wr_en, wr_bit, wr_idx, skip_req, flush_req, skip_cnt, skip_total,
                  e_wr, e_bit & e_wr, exp_idx, e_skip, exp_tot);
      end
   endtask

   // drives at a falling edge, samples one time step after the next rising edge
   task automatic step(input string req, input bit v, input bit b,
                       input bit e_wr, input bit e_bit, input int unsigned e_skip);
      act_valid = v;
      act_bit   = b;
      @(posedge clk);
      #1;
      if (e_skip != 0)
         exp_tot = (exp_tot + e_skip > SATV) ? SATV : exp_tot + e_skip;
      compare(req, e_wr, e_bit, e_skip);
      if (e_wr) exp_idx = (exp_idx + 1) % DEPTH;
      @(negedge clk);
      act_valid = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compare("R1 during reset", 1'b0, 1'b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release", 1'b0, 1'b0, 0);

      // R3 R4 R5 R6 R8 R9: every size, every hit position, plus no hit
      for (int n = 1; n <= int'(MAXP); n++) begin
         pool_size = PW'(n);
         for (int p = 0; p <= n; p++) begin
            for (int k = 0; k < n; k++) begin
               if (k < p) begin
                  if (k == n - 1) step("R5 zero window end", 1'b1, 1'b0, 1'b1, 1'b0, 0);
                  else            step("R5 zero element", 1'b1, 1'b0, 1'b0, 1'b0, 0);
               end else begin
                  step("R3 R4 hit", 1'b1, 1'b1, 1'b1, 1'b1, n - 1 - p);
                  break;
               end
            end
            if (((n + p) % 3) == 0) step("R9 idle", 1'b0, 1'b1, 1'b0, 1'b0, 0);
         end
      end

      // R7: zero size behaves as one
      pool_size = '0;
      step("R7 size0 zero", 1'b1, 1'b0, 1'b1, 1'b0, 0);
      step("R7 size0 one", 1'b1, 1'b1, 1'b1, 1'b1, 0);

      // R7: oversize clamps to MAX_POOL
      pool_size = PW'(31);
      for (int k = 0; k < int'(MAXP); k++)
         step("R7 clamp", 1'b1, 1'b0, (k == int'(MAXP) - 1), 1'b0, 0);
      step("R7 clamp hit", 1'b1, 1'b1, 1'b1, 1'b1, MAXP - 1);

      // R2 R6: bypass pass-through with index wrap
      bypass = 1'b1;
      pool_size = PW'(4);
      for (int i = 0; i < 40; i++)
         step("R2 bypass", 1'b1, ((i * 7) % 3) == 0, 1'b1, ((i * 7) % 3) == 0, 0);
      step("R9 bypass idle", 1'b0, 1'b1, 1'b0, 1'b0, 0);

      // R6: back to pooled mode, fresh window
      bypass = 1'b0;
      step("R6 pooled zero", 1'b1, 1'b0, 1'b0, 1'b0, 0);
      step("R6 pooled hit", 1'b1, 1'b1, 1'b1, 1'b1, 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule